// File: doc/BRIEF.md
# Command-Queue I2C Master

This block is a bus master for I2C and SMBus that software programs only through tagged command words. Each word goes into a 16-entry queue. A flag field in the word tells the engine what to do with its low byte. The byte can be an address sent after a start or repeated start, a data byte to send, or a count of bytes to read. A separate flag closes the transaction with a stop. Bytes fetched from the slave land in a 16-entry receive queue. Every read of that queue reports whether anything was there.

A small word-addressed register port gives access to four locations: the command queue (index 0), the receive queue (index 1), status (index 2) and control (index 3). The control register holds the SCL divider and two pulse bits that empty the queues. Status flags record completion, a slave NACK and command-queue overflow, and each is cleared by writing a one to it. Both bus lines are open-drain: the block only pulls a line low or releases it.

Top module: `cqi2c_master`

## Requirements
- R1: A command word with bit 8 set makes the engine emit a start condition (SDA falls while SCL is high, also as a repeated start after earlier bytes) and then shift out bits 7:0 MSB first as the address byte.
- R2: A command word with neither bit 8 nor bit 10 set shifts out bits 7:0 MSB first as a data byte, then releases SDA for one bit time and samples the slave's acknowledge (SDA low means ACK).
- R3: A command word with bit 10 set and no bit 8 reads N bytes from the slave, where N is bits 7:0. Each byte goes into the receive queue. The master drives ACK (SDA low) after each byte, except after the last byte of a word that also has bit 9 set, where it leaves SDA high (NACK).
- R4: Bit 9 of a command word makes the engine issue a stop condition (SDA rises while SCL is high) after that word's bytes. Completing the stop sets status bit 27. Writing 1 to bit 27 clears it and leaves the other status bits unchanged.
- R5: A read of register index 1 returns the oldest received byte in bits 7:0 with bit 8 clear, and removes that byte. When the queue is empty it returns 0x100 and removes nothing.
- R6: If the slave does not ACK a byte the master sent, the engine discards every queued command, issues a stop, and sets status bit 0 (cleared by writing 1). It also sets bit 27 once the stop completes.
- R7: A write to the command queue while it already holds 16 words is dropped and sets status bit 1. That bit stays set until 1 is written to it.
- R8: Control bits 7:0 hold the divider D, which resets to 84. The SCL period is 4*D core clocks, built from four quarter steps of D clocks each, and SCL changes only at a quarter step boundary.
- R9: Writing control bit 9 empties the command queue and writing bit 10 empties the receive queue. Both bits act only on the write and always read back as 0.
- R10: After a word without bit 9 the bus stays owned: no stop is issued and SCL is held low. The bytes read so far can be fetched, and a later read word continues the same transaction (two-step block read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata one cycle later |
| bus_addr | input | 2 | Register index: 0 command queue, 1 receive queue, 2 status, 3 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level sensed on the SDA line |

## Verification
Some behaviours are checked by the assertions on every cycle:
- SCL moves only right after a quarter-step tick.
- The overflow flag is set by a push into a full queue and holds until it is cleared.
- The done flag follows the stop pulse and its write-one-to-clear.
- An abort leaves the command queue empty and the NACK flag set.
- A read of an empty receive queue keeps it empty.
- The control reset bits read back as zero.

Other behaviours can only be shown by the bench scenarios, which run against a slave model on the wired-AND lines:
- the bit order on the bus and the start and stop shapes;
- the ACK and NACK pattern of counted reads;
- a bus held open between the two steps of a block read;
- the measured SCL period;
- the fact that commands discarded by an abort or a reset never reach the wire.

// File: rtl/cqi_pkg.sv
`timescale 1ns/1ps
package cqi_pkg;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 8;
  localparam int CMD_W  = 11;
  // command word flags
  localparam int F_START = 8;
  localparam int F_STOP  = 9;
  localparam int F_READ  = 10;
  // receive read-back
  localparam int RX_EMPTY_BIT = 8;
  // status bits
  localparam int S_NACK = 0;
  localparam int S_OVF  = 1;
  localparam int S_DONE = 27;
  // control bits
  localparam int C_TXRST = 9;
  localparam int C_RXRST = 10;
  // register indices
  localparam logic [1:0] A_CMD = 2'd0;
  localparam logic [1:0] A_RX  = 2'd1;
  localparam logic [1:0] A_STS = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} eng_st_e;
endpackage

// File: rtl/cqi_fifo.sv
`timescale 1ns/1ps
module cqi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];
endmodule

// File: rtl/cqi_engine.sv
`timescale 1ns/1ps
module cqi_engine
  import cqi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             cmd_empty,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             cmd_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             abort_p,
  output logic             done_p,
  output logic             tick_o,
  output logic             scl_low,
  output logic             sda_low,
  input  logic             sda_s
);
  logic [DIV_W-1:0] dcnt;
  logic             tick;
  eng_st_e          st;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [7:0]       sh, cnt;
  logic             rd_mode, stop_f, ack_bad;

  // quarter-step timebase
  assign tick = (div <= DIV_W'(1)) || (dcnt >= div - 1'b1);
  always_ff @(posedge clk) begin
    if (rst || tick) dcnt <= '0;
    else             dcnt <= dcnt + 1'b1;
  end

  assign tick_o  = tick;
  assign cmd_pop = tick && (st == ST_IDLE) && !cmd_empty;
  assign rx_byte = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; q <= '0; bitn <= '0; sh <= '0; cnt <= '0;
      rd_mode <= 1'b0; stop_f <= 1'b0; ack_bad <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0;
      rx_push <= 1'b0; done_p <= 1'b0; abort_p <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      done_p  <= 1'b0;
      abort_p <= 1'b0;
      if (tick) begin
        q <= q + 1'b1;
        case (st)
          ST_IDLE: begin
            q <= '0;
            if (!cmd_empty) begin
              stop_f <= cmd_word[F_STOP];
              bitn   <= '0;
              if (cmd_word[F_START]) begin
                sh <= cmd_word[7:0]; rd_mode <= 1'b0; st <= ST_START;
              end else if (cmd_word[F_READ]) begin
                cnt <= cmd_word[7:0]; rd_mode <= 1'b1;
                if (cmd_word[7:0] == 8'd0) st <= cmd_word[F_STOP] ? ST_STOP : ST_IDLE;
                else                       st <= ST_BIT;
              end else begin
                sh <= cmd_word[7:0]; rd_mode <= 1'b0; st <= ST_BIT;
              end
            end
          end
          ST_START: begin
            case (q)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: begin scl_low <= 1'b1; st <= ST_BIT; end
            endcase
          end
          ST_BIT: begin
            case (q)
              2'd0: sda_low <= (bitn == 4'd8) ? (rd_mode && !(cnt == 8'd1 && stop_f))
                                              : (!rd_mode && !sh[7]);
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (bitn == 4'd8) ack_bad <= sda_s;
                else if (rd_mode) sh <= {sh[6:0], sda_s};
              end
              default: begin
                scl_low <= 1'b1;
                if (bitn != 4'd8) begin
                  bitn <= bitn + 1'b1;
                  if (!rd_mode) sh <= {sh[6:0], 1'b0};
                end else begin
                  bitn <= '0;
                  if (rd_mode) begin
                    rx_push <= 1'b1;
                    cnt     <= cnt - 1'b1;
                    if (cnt == 8'd1) st <= stop_f ? ST_STOP : ST_IDLE;
                  end else if (ack_bad) begin
                    abort_p <= 1'b1;
                    st      <= ST_STOP;
                  end else begin
                    st <= stop_f ? ST_STOP : ST_IDLE;
                  end
                end
              end
            endcase
          end
          default: begin // ST_STOP
            case (q)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin done_p <= 1'b1; st <= ST_IDLE; end
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cqi2c_master.sv
`timescale 1ns/1ps
module cqi2c_master
  import cqi_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_RST    = 84
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic [DIV_W-1:0] div_q;
  logic             tx_full, tx_empty, tx_pop, tx_push, tx_clr;
  logic [CMD_W-1:0] tx_dout;
  logic             rx_full, rx_empty, rx_pop, rx_push, rx_clr;
  logic [7:0]       rx_dout, rx_byte;
  logic             abort_p, done_p, tick;
  logic             sda_m, sda_s;
  logic             sts_done, sts_nack, sts_ovf;
  logic             wr_ctl, wr_sts;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata[31:28], bus_wdata[26:11], rx_full};

  assign wr_ctl  = bus_wr && (bus_addr == A_CTL);
  assign wr_sts  = bus_wr && (bus_addr == A_STS);
  assign tx_push = bus_wr && (bus_addr == A_CMD);
  assign tx_clr  = (wr_ctl && bus_wdata[C_TXRST]) || abort_p;
  assign rx_clr  = wr_ctl && bus_wdata[C_RXRST];
  assign rx_pop  = bus_rd && (bus_addr == A_RX);

  cqi_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push), .din(bus_wdata[CMD_W-1:0]),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

  cqi_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  cqi_engine u_eng (
    .clk(clk), .rst(rst), .div(div_q), .cmd_empty(tx_empty), .cmd_word(tx_dout),
    .cmd_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte), .abort_p(abort_p),
    .done_p(done_p), .tick_o(tick), .scl_low(scl_oe), .sda_low(sda_oe), .sda_s(sda_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_m <= 1'b1; sda_s <= 1'b1;
      div_q <= DIV_W'(DIV_RST);
      sts_done <= 1'b0; sts_nack <= 1'b0; sts_ovf <= 1'b0;
    end else begin
      sda_m <= sda_in; sda_s <= sda_m;
      if (wr_ctl) div_q <= bus_wdata[DIV_W-1:0];
      sts_done <= done_p | (sts_done & !(wr_sts && bus_wdata[S_DONE]));
      sts_nack <= abort_p | (sts_nack & !(wr_sts && bus_wdata[S_NACK]));
      sts_ovf  <= (tx_push && tx_full) | (sts_ovf & !(wr_sts && bus_wdata[S_OVF]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        A_RX: begin
          bus_rdata[7:0]          <= rx_empty ? 8'h00 : rx_dout;
          bus_rdata[RX_EMPTY_BIT] <= rx_empty;
        end
        A_STS: begin
          bus_rdata[S_DONE] <= sts_done;
          bus_rdata[S_OVF]  <= sts_ovf;
          bus_rdata[S_NACK] <= sts_nack;
        end
        A_CTL:   bus_rdata[DIV_W-1:0] <= div_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cqi2c_master_chk.sv
`timescale 1ns/1ps
module cqi2c_master_chk
  import cqi_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              scl_oe,
  input logic              tick,
  input logic              tx_full,
  input logic              tx_empty,
  input logic              rx_empty,
  input logic              rx_push,
  input logic              done_p,
  input logic              abort_p,
  input logic              sts_done,
  input logic              sts_nack,
  input logic              sts_ovf
);
  logic unused_chk;
  assign unused_chk = ^{bus_wdata, bus_rdata};

  p_scl_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_oe) |-> $past(tick));

  p_ovf_set_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CMD && tx_full) |=> sts_ovf);

  p_no_overflow_loss_r7: assert property (@(posedge clk) disable iff (rst)
    (sts_ovf && !(bus_wr && bus_addr == A_STS && bus_wdata[S_OVF])) |=> sts_ovf);

  p_done_set_r4: assert property (@(posedge clk) disable iff (rst)
    done_p |=> sts_done);

  p_done_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_STS && bus_wdata[S_DONE] && !done_p) |=> !sts_done);

  p_abort_flush_r6: assert property (@(posedge clk) disable iff (rst)
    abort_p |=> (tx_empty && sts_nack));

  p_rx_nopop_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_RX && rx_empty && !rx_push) |=> rx_empty);

  p_ctl_selfclr_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_CTL) |=> (bus_rdata[C_RXRST:C_TXRST] == 2'b00));
endmodule

bind cqi2c_master cqi2c_master_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_oe(scl_oe), .tick(tick),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_empty(rx_empty), .rx_push(rx_push),
  .done_p(done_p), .abort_p(abort_p), .sts_done(sts_done), .sts_nack(sts_nack),
  .sts_ovf(sts_ovf));

// File: tb/sim_cqi2c_master.sv
`timescale 1ns/1ps
module sim_cqi2c_master;
  import cqi_pkg::*;

  localparam logic [6:0] SLV = 7'h50;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        scl_oe, sda_oe;
  logic        slv_low = 1'b0;
  wire         scl_line = !scl_oe;
  wire         sda_line = !(sda_oe || slv_low);

  cqi2c_master u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_line));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_wr[$];
  bit         exp_ack[$];
  logic [7:0] rd_src[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- slave model and monitor ----------------
  bit prev_scl = 1, prev_sda = 1, first = 0, tx_mode = 0, next_tx = 0, matched = 0, m_ack = 0;
  int bc = 0, stop_cnt = 0, last_rise = 0, per_meas = 0;
  logic [7:0] sh = '0;

  always @(negedge clk) begin
    bit s_scl, s_sda;
    s_scl = scl_line;
    s_sda = sda_line;
    if (!rst) begin
      if (prev_scl && s_scl && prev_sda && !s_sda) begin
        bc = 0; first = 1; tx_mode = 0; slv_low = 0;
      end else if (prev_scl && s_scl && !prev_sda && s_sda) begin
        stop_cnt++; bc = 0; first = 0; tx_mode = 0; slv_low = 0;
      end else if (!prev_scl && s_scl) begin
        if (bc >= 1 && bc <= 7) per_meas = cyc - last_rise;
        last_rise = cyc;
        if (bc < 8) begin
          if (!tx_mode) sh = {sh[6:0], s_sda};
          bc++;
          if (bc == 8 && !tx_mode) begin
            if (first) begin
              matched = (sh[7:1] == SLV);
              next_tx = sh[0] && matched;
            end else next_tx = 0;
            if (exp_wr.size() == 0) chk(0, first ? "R1 unexpected byte" : "R2 unexpected byte", sh, 0);
            else begin
              logic [7:0] e;
              e = exp_wr.pop_front();
              chk(sh == e, first ? "R1 address byte" : "R2 data byte", sh, e);
            end
            first = 0;
          end
        end else if (bc == 8) begin
          if (tx_mode) begin
            m_ack = !s_sda;
            if (exp_ack.size() == 0) chk(0, "R3 unexpected ack slot", m_ack, 0);
            else begin
              bit ea;
              ea = exp_ack.pop_front();
              chk(m_ack == ea, "R3 master ack/nack", m_ack, ea);
            end
          end
          bc = 9;
        end
      end else if (prev_scl && !s_scl) begin
        if (bc == 8) slv_low = !tx_mode && matched;
        else if (bc == 9) begin
          bc = 0;
          if ((tx_mode && m_ack) || (!tx_mode && next_tx)) begin
            tx_mode = 1;
            sh = (rd_src.size() != 0) ? rd_src.pop_front() : 8'hFF;
            slv_low = !sh[7];
          end else begin
            tx_mode = 0; slv_low = 0;
          end
          next_tx = 0;
        end else if (tx_mode && bc >= 1 && bc <= 7) slv_low = !sh[7-bc];
      end
    end
    prev_scl = s_scl;
    prev_sda = s_sda;
  end

  // ---------------- driver tasks ----------------
  task automatic bus_w(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_r(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic drv_wbyte(input logic [10:0] w);
    exp_wr.push_back(w[7:0]);
    bus_w(A_CMD, 32'(w));
  endtask

  task automatic drv_read(input int n, input bit stop);
    for (int i = 0; i < n; i++) exp_ack.push_back(!(stop && i == n - 1));
    bus_w(A_CMD, 32'(n) | (1 << F_READ) | (stop ? (1 << F_STOP) : 0));
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] d;
    int k;
    d = '0;
    for (k = 0; k < 5000 && !d[S_DONE]; k++) bus_r(A_STS, d);
    chk(d[S_DONE], {tag, " done flag"}, d, 32'h0800_0000);
    bus_w(A_STS, 32'h0800_0000);
    bus_r(A_STS, d);
    chk(!d[S_DONE], "R4 done cleared by W1C", d[S_DONE], 0);
  endtask

  task automatic rx_expect(input logic [31:0] e, input string tag);
    logic [31:0] d;
    bus_r(A_RX, d);
    chk(d == e, tag, d, e);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all requirements act=%0d exp<%0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0] d;
    int sc;
    repeat (5) @(negedge clk);
    rst = 0;

    bus_r(A_STS, d); chk(d == 0, "R4 status after reset", d, 0);
    bus_r(A_CTL, d); chk(d == 84, "R8 divider reset value", d, 84);
    rx_expect(32'h100, "R5 empty receive read");
    bus_w(A_CTL, 4);
    bus_r(A_CTL, d); chk(d == 4, "R8 divider readback", d, 4);

    // write transfer
    drv_wbyte(11'h100 | 11'(SLV << 1));
    drv_wbyte(11'h0A5);
    drv_wbyte(11'h200 | 11'h03C);
    wait_done("R4");
    chk(stop_cnt == 1, "R4 stop count", stop_cnt, 1);
    chk(per_meas == 16, "R8 SCL period", per_meas, 16);
    bus_r(A_STS, d); chk(d == 0, "R2 ack seen, no error", d, 0);

    // counted read with stop
    rd_src.push_back(8'h11); rd_src.push_back(8'h22); rd_src.push_back(8'h33);
    drv_wbyte(11'h100 | 11'(SLV << 1) | 11'h1);
    drv_read(3, 1);
    wait_done("R3");
    rx_expect(32'h11, "R3 first byte");
    rx_expect(32'h22, "R3 second byte");
    rx_expect(32'h33, "R3 third byte");
    rx_expect(32'h100, "R5 empty after drain");
    rx_expect(32'h100, "R5 empty read pops nothing");

    // two-step block read
    rd_src.push_back(8'h02); rd_src.push_back(8'hC1); rd_src.push_back(8'hC2);
    sc = stop_cnt;
    drv_wbyte(11'h100 | 11'(SLV << 1) | 11'h1);
    drv_read(1, 0);
    d = 32'h100;
    for (int k = 0; k < 2000 && d[8]; k++) bus_r(A_RX, d);
    chk(d == 32'h02, "R10 count byte", d, 2);
    repeat (40) @(negedge clk);
    chk(scl_oe == 1'b1, "R10 SCL held low", scl_oe, 1);
    chk(stop_cnt == sc, "R10 no stop yet", stop_cnt, sc);
    drv_read(2, 1);
    wait_done("R10");
    rx_expect(32'hC1, "R10 block byte 1");
    rx_expect(32'hC2, "R10 block byte 2");

    // NACK abort
    drv_wbyte(11'h100 | 11'h084);
    bus_w(A_CMD, 32'h055);
    bus_w(A_CMD, 32'h266);
    wait_done("R6");
    bus_r(A_STS, d); chk(d[S_NACK], "R6 nack flag", d, 1);
    bus_w(A_STS, 32'h1);
    bus_r(A_STS, d); chk(d == 0, "R6 nack flag W1C", d, 0);
    drv_wbyte(11'h100 | 11'(SLV << 1));
    drv_wbyte(11'h200 | 11'h05A);
    wait_done("R6");

    // receive queue reset
    rd_src.push_back(8'h01); rd_src.push_back(8'h02);
    drv_wbyte(11'h100 | 11'(SLV << 1) | 11'h1);
    drv_read(2, 1);
    wait_done("R9");
    bus_w(A_CTL, (1 << C_RXRST) | 4);
    rx_expect(32'h100, "R9 receive queue emptied");
    bus_r(A_CTL, d); chk(d == 4, "R9 reset bits self-clear", d, 4);

    // overflow and command queue reset
    bus_w(A_CTL, 255);
    drv_wbyte(11'h100 | 11'(SLV << 1));
    repeat (600) @(negedge clk);
    for (int i = 0; i < 20; i++) bus_w(A_CMD, 32'h099);
    bus_r(A_STS, d); chk(d[S_OVF], "R7 overflow flag", d, 2);
    bus_w(A_CTL, (1 << C_TXRST) | 4);
    drv_wbyte(11'h200 | 11'h077);
    wait_done("R9");
    bus_r(A_STS, d); chk(d == 2, "R7 overflow sticky", d, 2);
    bus_w(A_STS, 32'h2);
    bus_r(A_STS, d); chk(d == 0, "R7 overflow W1C", d, 0);

    repeat (50) @(negedge clk);
    chk(exp_wr.size() == 0, "R1 all expected bytes seen", exp_wr.size(), 0);
    chk(exp_ack.size() == 0, "R3 all ack slots seen", exp_ack.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule